// File: doc/BRIEF.md
# I2C Combined-Transfer Chunk Sequencer

This block runs one complete I2C transaction on top of a byte-level master engine. A transaction consists of an optional register-address phase, which is always a write, followed by a data phase that is either a read or a write. The sequencer breaks each phase into chunks of at most four bytes. For every chunk it loads the engine's write buffer, issues a command word, and polls for completion.

The command word carries four things: the chunk size, a chain flag that keeps the bus held between chunks, a repeated-start flag, and a read flag. A write transaction therefore forms one unbroken bus transfer. A read turns the bus around with a repeated start exactly where the address phase ends.

Write data arrives on a valid/ready byte stream, and read data leaves on another. When the transaction finishes, the block pulses `done` and presents a 3-bit result code. The bit-level signalling belongs to the engine, which this block only drives and observes.

Top module: `i2c_chunk_seq`

## Requirements
- R1: Each chunk carries min(4, bytes left in its phase) bytes. Its command word has bit 0 (go) set and holds the chunk size minus one in bits [5:4].
- R2: Bit 2 (chain) of the command word is set on every chunk that has further chunks of the same phase after it. It is also set on every address-phase chunk of a write transaction.
- R3: On the last address-phase chunk of a read transaction, bit 3 (repeated start) is set and bit 2 (chain) is clear. Bit 3 is clear on every other chunk.
- R4: Bit 1 (read) is set only on data-phase chunks of a read transaction. Address-phase chunks never have it, and for an address-phase chunk the block pushes the address bytes into the engine buffer.
- R5: An address length of 0 skips the address phase. Otherwise the block sends the low address-length bytes of the 32-bit register address, most significant byte first.
- R6: A data length of 0, or an address length above 4, ends the transaction with result 1. No command is issued.
- R7: Before the first chunk, the block waits up to PRE_WAIT cycles for `engPending` to drop. If it stays high, the result is 2 and no command is issued.
- R8: After issuing a chunk, the block samples engine status once every POLL_DIV cycles. If `engPending` is still high after POLL_LIMIT samples, the result is 2.
- R9: If `engError` is seen at a sample, the result is chosen by priority: 3 if `engAbort` is set, else 4 if `engIncomplete` is set, else 5 if `engLostArb` is set, else 6.
- R10: If a read chunk completes while `engRdAvail` is low, the result is 7.
- R11: `busy` is high from the cycle after a start is accepted until the end of the single `done` cycle. `result` is valid during `done`, and a successful transaction returns 0.
- R12: Write data bytes are taken from the tx stream in arrival order. Read bytes popped from the engine are delivered on the rx stream in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a transaction (taken while idle) |
| devAddr | input | 7 | Target device address |
| regAddr | input | 32 | Register address value |
| addrLen | input | 3 | Register address length in bytes |
| readMode | input | 1 | 1 selects a read data phase |
| dataLen | input | LEN_W | Data phase length in bytes |
| txData | input | 8 | Write data byte |
| txValid | input | 1 | Write data valid |
| txReady | output | 1 | Write data accepted |
| rxData | output | 8 | Read data byte |
| rxValid | output | 1 | Read data valid |
| rxReady | input | 1 | Read data sink ready |
| engDevAddr | output | 7 | Latched device address for the engine |
| engWrData | output | 8 | Byte pushed into the engine buffer |
| engWrValid | output | 1 | Engine buffer push strobe |
| engCmd | output | 8 | Chunk command word |
| engCmdValid | output | 1 | Command issue strobe |
| engPending | input | 1 | Engine transfer in progress |
| engError | input | 1 | Engine reports a failed chunk |
| engAbort | input | 1 | Failure cause: aborted |
| engIncomplete | input | 1 | Failure cause: incomplete transfer |
| engLostArb | input | 1 | Failure cause: lost arbitration |
| engRdData | input | 8 | Received byte at engine buffer head |
| engRdAvail | input | 1 | Received data available |
| engRdPop | output | 1 | Pop one received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code |

## Verification
The bench runs several transaction shapes:

- a write with a two-byte address and five data bytes, where the address chunk is chained and the data splits 4+1;
- a read with a one-byte address, which carries the repeated start;
- writes and reads with no address phase;
- a write with a four-byte address, which shows the full byte order;
- a nine-byte read, which shows chaining across three data chunks.

Comparing the logged command words and bytes tells apart errors in chunk sizing, chain/restart placement, the read flag, and address byte order. The fault cases are given their own engine behaviour: a pending flag held at start, an engine that never completes, each combination of error flags, and a read with no data. Each case is meant to produce exactly its own result code, and the start-time faults must also produce no command.

// File: rtl/i2cSeqPkg.sv
package i2cSeqPkg;

  localparam int MAX_CHUNK  = 4;
  localparam int CMD_GO     = 0;
  localparam int CMD_READ   = 1;
  localparam int CMD_CHAIN  = 2;
  localparam int CMD_RPT    = 3;
  localparam int CMD_CNT_LO = 4;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_BADARG     = 3'd1,
    RES_TIMEOUT    = 3'd2,
    RES_ABORT      = 3'd3,
    RES_INCOMPLETE = 3'd4,
    RES_LOSTARB    = 3'd5,
    RES_FAIL       = 3'd6,
    RES_NODATA     = 3'd7
  } resultT;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_LOAD, S_ISSUE, S_WAIT, S_DRAIN, S_FIN
  } stateT;

  typedef struct packed {
    logic latch;
    logic loadActive;
    logic issue;
    logic drainActive;
    logic advance;
  } seqStrobeT;

endpackage

// File: rtl/seqData.sv
module seqData
  import i2cSeqPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        stb,
  input  logic [6:0]       devAddrIn,
  input  logic [31:0]      regAddrIn,
  input  logic [2:0]       addrLenIn,
  input  logic             readIn,
  input  logic [LEN_W-1:0] dataLenIn,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [6:0]       engDevAddr,
  output logic [7:0]       engWrData,
  output logic             engWrValid,
  output logic [7:0]       engCmd,
  input  logic [7:0]       engRdData,
  input  logic             engRdAvail,
  output logic             engRdPop,
  output logic             byteLast,
  output logic             readChunk,
  output logic             finalChunk,
  output logic             wrFire,
  output logic             popFire
);

  logic [31:0]      addrReg;
  logic [LEN_W-1:0] dataLenReg;
  logic [LEN_W-1:0] remain;
  logic [6:0]       devReg;
  logic             readReg;
  logic             inAddr;
  logic [1:0]       idx;

  logic             lastChunk;
  logic [2:0]       chunkSz;
  logic [1:0]       cntField;
  logic [2:0]       shiftFull;
  logic [7:0]       addrByte;
  logic             byteAvail;

  assign lastChunk = (remain <= LEN_W'(MAX_CHUNK));
  assign chunkSz   = lastChunk ? remain[2:0] : 3'(MAX_CHUNK);
  assign cntField  = 2'(chunkSz - 3'd1);
  assign byteLast  = ({1'b0, idx} == 3'(chunkSz - 3'd1));

  assign readChunk  = readReg && !inAddr;
  assign finalChunk = lastChunk && !inAddr;

  // most significant of the selected low bytes goes first
  assign shiftFull = 3'(remain[2:0] - 3'd1 - {1'b0, idx});
  assign addrByte  = addrReg[{shiftFull[1:0], 3'b000} +: 8];

  assign byteAvail  = inAddr ? 1'b1 : txValid;
  assign engWrValid = stb.loadActive && byteAvail;
  assign engWrData  = inAddr ? addrByte : txData;
  assign txReady    = stb.loadActive && !inAddr;
  assign wrFire     = engWrValid;

  assign rxValid  = stb.drainActive && engRdAvail;
  assign rxData   = engRdData;
  assign engRdPop = rxValid && rxReady;
  assign popFire  = engRdPop;

  assign engDevAddr = devReg;

  always_comb begin
    engCmd = '0;
    engCmd[CMD_GO] = 1'b1;
    engCmd[CMD_CNT_LO +: 2] = cntField;
    engCmd[CMD_READ] = readChunk;
    engCmd[CMD_CHAIN] = (inAddr && !readReg) || !lastChunk;
    engCmd[CMD_RPT] = inAddr && readReg && lastChunk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      dataLenReg <= '0;
      remain     <= '0;
      devReg     <= '0;
      readReg    <= 1'b0;
      inAddr     <= 1'b0;
      idx        <= '0;
    end else if (stb.latch) begin
      addrReg    <= regAddrIn;
      dataLenReg <= dataLenIn;
      devReg     <= devAddrIn;
      readReg    <= readIn;
      inAddr     <= (addrLenIn != 3'd0);
      remain     <= (addrLenIn != 3'd0) ? LEN_W'(addrLenIn) : dataLenIn;
      idx        <= '0;
    end else if (stb.advance) begin
      idx <= '0;
      if (inAddr && lastChunk) begin
        inAddr <= 1'b0;
        remain <= dataLenReg;
      end else begin
        remain <= remain - LEN_W'(chunkSz);
      end
    end else if (wrFire || popFire) begin
      idx <= idx + 2'd1;
    end
  end

endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import i2cSeqPkg::*;
#(
  parameter int PRE_WAIT   = 10,
  parameter int POLL_DIV   = 4,
  parameter int POLL_LIMIT = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       argsOk,
  input  logic       engPending,
  input  logic       engError,
  input  logic       engAbort,
  input  logic       engIncomplete,
  input  logic       engLostArb,
  input  logic       engRdAvail,
  input  logic       byteLast,
  input  logic       readChunk,
  input  logic       finalChunk,
  input  logic       wrFire,
  input  logic       popFire,
  output seqStrobeT  stb,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);

  localparam int PRE_W  = $clog2(PRE_WAIT + 1);
  localparam int TICK_W = $clog2(POLL_DIV + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  stateT             state;
  resultT            resReg;
  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              tick;
  logic              drainEnd;
  resultT            errCode;

  assign tick     = (tickCnt == TICK_W'(POLL_DIV - 1));
  assign drainEnd = (state == S_DRAIN) && popFire && byteLast;

  always_comb begin
    if (engAbort)           errCode = RES_ABORT;
    else if (engIncomplete) errCode = RES_INCOMPLETE;
    else if (engLostArb)    errCode = RES_LOSTARB;
    else                    errCode = RES_FAIL;
  end

  always_comb begin
    stb = '0;
    stb.latch       = (state == S_IDLE) && start && argsOk;
    stb.loadActive  = (state == S_LOAD) && !readChunk;
    stb.issue       = (state == S_ISSUE);
    stb.drainActive = (state == S_DRAIN);
    stb.advance     = drainEnd ||
                      ((state == S_WAIT) && tick && !engError &&
                       !engPending && !readChunk);
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
  assign result = resReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      resReg  <= RES_OK;
      preCnt  <= '0;
      tickCnt <= '0;
      pollCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            if (!argsOk) begin
              resReg <= RES_BADARG;
              state  <= S_FIN;
            end else begin
              preCnt <= '0;
              state  <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (!engPending) begin
            state <= S_LOAD;
          end else if (preCnt == PRE_W'(PRE_WAIT - 1)) begin
            resReg <= RES_TIMEOUT;
            state  <= S_FIN;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        S_LOAD: begin
          if (readChunk || (wrFire && byteLast)) state <= S_ISSUE;
        end
        S_ISSUE: begin
          tickCnt <= '0;
          pollCnt <= '0;
          state   <= S_WAIT;
        end
        S_WAIT: begin
          if (!tick) begin
            tickCnt <= tickCnt + 1'b1;
          end else begin
            tickCnt <= '0;
            if (engError) begin
              resReg <= errCode;
              state  <= S_FIN;
            end else if (!engPending) begin
              if (readChunk) begin
                if (engRdAvail) begin
                  state <= S_DRAIN;
                end else begin
                  resReg <= RES_NODATA;
                  state  <= S_FIN;
                end
              end else if (finalChunk) begin
                resReg <= RES_OK;
                state  <= S_FIN;
              end else begin
                state <= S_LOAD;
              end
            end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
              resReg <= RES_TIMEOUT;
              state  <= S_FIN;
            end else begin
              pollCnt <= pollCnt + 1'b1;
            end
          end
        end
        S_DRAIN: begin
          if (drainEnd) begin
            if (finalChunk) begin
              resReg <= RES_OK;
              state  <= S_FIN;
            end else begin
              state <= S_LOAD;
            end
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2cSeqPkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PRE_WAIT   = 10,
  parameter int POLL_DIV   = 4,
  parameter int POLL_LIMIT = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [6:0]       devAddr,
  input  logic [31:0]      regAddr,
  input  logic [2:0]       addrLen,
  input  logic             readMode,
  input  logic [LEN_W-1:0] dataLen,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [6:0]       engDevAddr,
  output logic [7:0]       engWrData,
  output logic             engWrValid,
  output logic [7:0]       engCmd,
  output logic             engCmdValid,
  input  logic             engPending,
  input  logic             engError,
  input  logic             engAbort,
  input  logic             engIncomplete,
  input  logic             engLostArb,
  input  logic [7:0]       engRdData,
  input  logic             engRdAvail,
  output logic             engRdPop,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result
);

  seqStrobeT stb;
  logic      argsOk;
  logic      byteLast, readChunk, finalChunk, wrFire, popFire;

  assign argsOk      = (dataLen != '0) && (addrLen <= 3'(MAX_CHUNK));
  assign engCmdValid = stb.issue;

  seqCtrl #(
    .PRE_WAIT  (PRE_WAIT),
    .POLL_DIV  (POLL_DIV),
    .POLL_LIMIT(POLL_LIMIT)
  ) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .argsOk       (argsOk),
    .engPending   (engPending),
    .engError     (engError),
    .engAbort     (engAbort),
    .engIncomplete(engIncomplete),
    .engLostArb   (engLostArb),
    .engRdAvail   (engRdAvail),
    .byteLast     (byteLast),
    .readChunk    (readChunk),
    .finalChunk   (finalChunk),
    .wrFire       (wrFire),
    .popFire      (popFire),
    .stb          (stb),
    .busy         (busy),
    .done         (done),
    .result       (result)
  );

  seqData #(.LEN_W(LEN_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .devAddrIn (devAddr),
    .regAddrIn (regAddr),
    .addrLenIn (addrLen),
    .readIn    (readMode),
    .dataLenIn (dataLen),
    .txData    (txData),
    .txValid   (txValid),
    .txReady   (txReady),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .rxReady   (rxReady),
    .engDevAddr(engDevAddr),
    .engWrData (engWrData),
    .engWrValid(engWrValid),
    .engCmd    (engCmd),
    .engRdData (engRdData),
    .engRdAvail(engRdAvail),
    .engRdPop  (engRdPop),
    .byteLast  (byteLast),
    .readChunk (readChunk),
    .finalChunk(finalChunk),
    .wrFire    (wrFire),
    .popFire   (popFire)
  );

endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [2:0]       addrLen,
  input logic [LEN_W-1:0] dataLen,
  input logic             busy,
  input logic             done,
  input logic [2:0]       result,
  input logic [7:0]       engCmd,
  input logic             engCmdValid,
  input logic             engWrValid,
  input logic             engRdPop
);

  AST_CHAIN_RPT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> !(engCmd[2] && engCmd[3])); // R3

  AST_READ_NO_RPT: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid && engCmd[1] |-> !engCmd[3]); // R4

  AST_GO_SET: assert property (@(posedge clk) disable iff (!rstN)
    engCmdValid |-> engCmd[0]); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !engCmdValid && !engWrValid && !engRdPop); // R11

  AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (dataLen == '0) |=> done && (result == 3'd1)); // R6

  AST_BAD_ALEN: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (addrLen > 3'd4) |=> done && !engCmdValid); // R6

endmodule

bind i2c_chunk_seq seqChecker #(.LEN_W(LEN_W)) chk (.*);

// File: tb/i2c_chunk_seq_test.sv
`timescale 1ns/1ps
module i2c_chunk_seq_test;

  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic [6:0]       devAddr = 7'h50;
  logic [31:0]      regAddr = '0;
  logic [2:0]       addrLen = '0;
  logic             readMode = 1'b0;
  logic [LEN_W-1:0] dataLen = '0;
  logic [7:0]       txData;
  logic             txValid;
  logic             txReady;
  logic [7:0]       rxData;
  logic             rxValid;
  logic             rxReady;
  logic [6:0]       engDevAddr;
  logic [7:0]       engWrData;
  logic             engWrValid;
  logic [7:0]       engCmd;
  logic             engCmdValid;
  logic             engPending, engError, engAbort, engIncomplete, engLostArb;
  logic [7:0]       engRdData;
  logic             engRdAvail;
  logic             engRdPop;
  logic             busy, done;
  logic [2:0]       result;

  i2c_chunk_seq #(.LEN_W(LEN_W), .PRE_WAIT(10), .POLL_DIV(2), .POLL_LIMIT(80)) uut (.*);

  // engine model controls
  bit stuck = 0, forcePend = 0, noData = 0, errOn = 0;
  bit errAb = 0, errIc = 0, errLa = 0;

  logic       pendReg, errReg, abReg, icReg, laReg, curRead;
  int         lat, rdLeft, curSz;
  logic [7:0] rdNext, txNext;
  logic [7:0] cmdLog [256];
  logic [7:0] wrLog  [256];
  logic [7:0] rxLog  [256];
  int         cmdCnt, wrCnt, rxCnt, doneCnt;

  assign engPending    = pendReg | forcePend;
  assign engError      = errReg;
  assign engAbort      = abReg;
  assign engIncomplete = icReg;
  assign engLostArb    = laReg;
  assign engRdAvail    = (rdLeft > 0);
  assign engRdData     = rdNext;
  assign txValid       = 1'b1;
  assign txData        = txNext;
  assign rxReady       = 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      pendReg <= 0; errReg <= 0; abReg <= 0; icReg <= 0; laReg <= 0;
      curRead <= 0; lat <= 0; rdLeft <= 0; curSz <= 0;
    end else begin
      if (engCmdValid) begin
        cmdLog[cmdCnt] <= engCmd;
        cmdCnt <= cmdCnt + 1;
        pendReg <= 1; errReg <= 0; abReg <= 0; icReg <= 0; laReg <= 0;
        lat <= 3;
        curRead <= engCmd[1];
        curSz <= int'(engCmd[5:4]) + 1;
      end else if (pendReg && lat > 0) begin
        lat <= lat - 1;
      end else if (pendReg && !stuck) begin
        pendReg <= 0;
        if (errOn) begin
          errReg <= 1; abReg <= errAb; icReg <= errIc; laReg <= errLa;
        end else if (curRead && !noData) begin
          rdLeft <= curSz;
        end
      end
      if (engRdPop) begin
        rdNext <= rdNext + 8'd1;
        rdLeft <= rdLeft - 1;
      end
    end
  end

  initial begin
    cmdCnt = 0; wrCnt = 0; rxCnt = 0; doneCnt = 0;
    rdNext = 8'h80; txNext = 8'h40;
  end

  always @(posedge clk) begin
    if (engWrValid) begin wrLog[wrCnt] <= engWrData; wrCnt <= wrCnt + 1; end
    if (txValid && txReady) txNext <= txNext + 8'd1;
    if (rxValid && rxReady) begin rxLog[rxCnt] <= rxData; rxCnt <= rxCnt + 1; end
    if (done) doneCnt <= doneCnt + 1;
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  int cmdBase, wrBase, rxBase, doneBase;
  logic [7:0] txBase, rxStart;
  logic [2:0] gotRes;

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic runTxn(input [31:0] ra, input [2:0] al, input bit rd,
                        input [LEN_W-1:0] dl, input string req);
    int guard;
    @(negedge clk);
    cmdBase = cmdCnt; wrBase = wrCnt; rxBase = rxCnt; doneBase = doneCnt;
    txBase = txNext; rxStart = rdNext;
    regAddr = ra; addrLen = al; readMode = rd; dataLen = dl;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, {req, " R11 busy after accept"}, int'(busy), 1);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk); guard++;
    end
    gotRes = result;
    @(negedge clk);
    check(busy == 1'b0 && doneCnt == doneBase + 1, {req, " R11 single done"},
          doneCnt - doneBase, 1);
  endtask

  task automatic expCmd(input int i, input [7:0] exp, input string req);
    check(cmdLog[cmdBase + i] == exp, req, int'(cmdLog[cmdBase + i]), int'(exp));
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0 && engCmdValid == 0, "R11 reset idle",
          int'({busy, done, engCmdValid}), 0);
  endtask

  task automatic testWriteAddr2();
    runTxn(32'h1122A1B2, 3'd2, 0, 16'd5, "wr2");
    check(gotRes == 3'd0, "R11 write ok", gotRes, 0);
    check(cmdCnt - cmdBase == 3, "R1 write chunk count", cmdCnt - cmdBase, 3);
    expCmd(0, 8'h15, "R2 addr chunk chained on write");
    expCmd(1, 8'h35, "R2 data chunk chained, size 4");
    expCmd(2, 8'h01, "R1 final chunk size 1");
    check(wrLog[wrBase] == 8'hA1 && wrLog[wrBase + 1] == 8'hB2, "R5 addr MSB first",
          int'({wrLog[wrBase], wrLog[wrBase + 1]}), 32'hA1B2);
    for (int i = 0; i < 5; i++)
      check(wrLog[wrBase + 2 + i] == 8'(txBase + 8'(i)), "R12 tx data order",
            int'(wrLog[wrBase + 2 + i]), int'(8'(txBase + 8'(i))));
    check(engDevAddr == 7'h50, "R11 device address", int'(engDevAddr), 'h50);
  endtask

  task automatic testReadAddr1();
    runTxn(32'hFFFFFF5C, 3'd1, 1, 16'd6, "rd1");
    check(gotRes == 3'd0, "R11 read ok", gotRes, 0);
    check(cmdCnt - cmdBase == 3, "R1 read chunk count", cmdCnt - cmdBase, 3);
    expCmd(0, 8'h09, "R3 repeated start on last addr chunk");
    expCmd(1, 8'h37, "R4 read chunk chained");
    expCmd(2, 8'h13, "R4 last read chunk size 2");
    check(wrCnt - wrBase == 1 && wrLog[wrBase] == 8'h5C, "R4 addr written on read",
          int'(wrLog[wrBase]), 'h5C);
    check(rxCnt - rxBase == 6, "R12 rx count", rxCnt - rxBase, 6);
    for (int i = 0; i < 6; i++)
      check(rxLog[rxBase + i] == 8'(rxStart + 8'(i)), "R12 rx order",
            int'(rxLog[rxBase + i]), int'(8'(rxStart + 8'(i))));
  endtask

  task automatic testNoAddr();
    runTxn(32'h0, 3'd0, 0, 16'd3, "wr0");
    check(gotRes == 3'd0 && cmdCnt - cmdBase == 1, "R5 no addr phase",
          cmdCnt - cmdBase, 1);
    expCmd(0, 8'h21, "R1 single 3-byte write chunk");
    check(wrCnt - wrBase == 3 && wrLog[wrBase] == txBase, "R5 data first when no addr",
          int'(wrLog[wrBase]), int'(txBase));
  endtask

  task automatic testAddr4();
    runTxn(32'hDEADBEEF, 3'd4, 0, 16'd4, "wr4");
    expCmd(0, 8'h35, "R2 4-byte addr chunk");
    expCmd(1, 8'h31, "R2 last data chunk unchained");
    check({wrLog[wrBase], wrLog[wrBase + 1], wrLog[wrBase + 2], wrLog[wrBase + 3]}
          == 32'hDEADBEEF, "R5 addr byte order",
          int'({wrLog[wrBase], wrLog[wrBase + 1], wrLog[wrBase + 2], wrLog[wrBase + 3]}),
          32'hDEADBEEF);
  endtask

  task automatic testRead9();
    runTxn(32'h0, 3'd0, 1, 16'd9, "rd9");
    check(gotRes == 3'd0 && cmdCnt - cmdBase == 3, "R1 nine bytes in three chunks",
          cmdCnt - cmdBase, 3);
    expCmd(0, 8'h37, "R2 read chain 1");
    expCmd(1, 8'h37, "R2 read chain 2");
    expCmd(2, 8'h03, "R4 last read chunk size 1");
    check(wrCnt == wrBase, "R4 no buffer writes on pure read", wrCnt - wrBase, 0);
  endtask

  task automatic testBadArgs();
    runTxn(32'h0, 3'd1, 0, 16'd0, "len0");
    check(gotRes == 3'd1 && cmdCnt == cmdBase, "R6 zero length rejected", gotRes, 1);
    runTxn(32'h0, 3'd5, 0, 16'd2, "alen5");
    check(gotRes == 3'd1 && cmdCnt == cmdBase && wrCnt == wrBase,
          "R6 address length 5 rejected", gotRes, 1);
  endtask

  task automatic testPreTimeout();
    forcePend = 1;
    runTxn(32'h0, 3'd0, 0, 16'd1, "pre");
    forcePend = 0;
    check(gotRes == 3'd2 && cmdCnt == cmdBase, "R7 pending before start", gotRes, 2);
  endtask

  task automatic testStuck();
    int t0;
    stuck = 1;
    t0 = 0;
    runTxn(32'h0, 3'd0, 0, 16'd1, "stuck");
    check(gotRes == 3'd2 && cmdCnt - cmdBase == 1, "R8 chunk wait timeout", gotRes, 2);
    stuck = 0;
    doReset();
  endtask

  task automatic testErr(input bit a, input bit ic, input bit la, input [2:0] exp);
    errOn = 1; errAb = a; errIc = ic; errLa = la;
    runTxn(32'h0, 3'd0, 0, 16'd1, "err");
    check(gotRes == exp, "R9 error priority", gotRes, exp);
    errOn = 0;
  endtask

  task automatic testNoData();
    noData = 1;
    runTxn(32'h0, 3'd0, 1, 16'd2, "nodata");
    check(gotRes == 3'd7 && cmdCnt - cmdBase == 1, "R10 read without data", gotRes, 7);
    noData = 0;
  endtask

  initial begin
    doReset();
    testReset();
    testWriteAddr2();
    testReadAddr1();
    testNoAddr();
    testAddr4();
    testRead9();
    testBadArgs();
    testPreTimeout();
    testStuck();
    testErr(1, 1, 1, 3'd3);
    testErr(0, 1, 1, 3'd4);
    testErr(0, 0, 1, 3'd5);
    testErr(0, 0, 0, 3'd6);
    testNoData();
    testWriteAddr2();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule